// File: doc/BRIEF.md
# Packed Unsigned Lane Add/Subtract Unit

This unit is a SIMD arithmetic stage for a 32-bit processor datapath. Each accepted operation splits two register operands into either two 16-bit lanes or four 8-bit lanes. It then does unsigned lane-wise addition or subtraction, or one of two crossed forms that pair the low half of one operand with the high half of the other. It returns a packed 32-bit destination value and a 4-bit greater-or-equal flag vector with one bit per byte position.

An operation enters with `inValid` and leaves one clock later with `outValid`. It executes only when its condition field holds the always-code or the external `condPass` input is high. A skipped operation, or one with an unused selector code, leaves both the destination value and the flag register as they were. The `wrEn` output tells the register file whether to take `result`.

Top module: `lane_addsub_unit`

## Requirements
- R1: Selector 3'd0 adds the low halves into result[15:0] and the high halves into result[31:16], each modulo 2^16. GE[1:0] are both set when the low sum is 0x10000 or more, and GE[3:2] are both set when the high sum is 0x10000 or more.
- R2: Selector 3'd3 subtracts opB from opA in each half, modulo 2^16. A half's two GE bits are set when its difference is not negative, that is, when no borrow occurs.
- R3: Selector 3'd1 (add/subtract exchange) gives result[15:0] = opA[15:0] - opB[31:16], with GE[1:0] set on no borrow. It gives result[31:16] = opA[31:16] + opB[15:0], with GE[3:2] set on carry out.
- R4: Selector 3'd2 (subtract/add exchange) gives result[15:0] = opA[15:0] + opB[31:16], with GE[1:0] set on carry out. It gives result[31:16] = opA[31:16] - opB[15:0], with GE[3:2] set on no borrow.
- R5: Selector 3'd4 adds byte lane i (bits [8i+7:8i]) of both operands modulo 256 into the same byte of the result. GE[i] is set when that sum is 0x100 or more.
- R6: Selector 3'd7 subtracts byte lane i of opB from opA modulo 256 into the same byte of the result. GE[i] is set when the difference is not negative.
- R7: In every 16-bit mode (selectors 0 to 3), GE[0] equals GE[1] and GE[2] equals GE[3] after an executed operation.
- R8: An operation executes only if condField equals 4'b1110 or condPass is high. A non-executing operation gives wrEn low and leaves result and geFlags unchanged.
- R9: Selector codes 3'd5 and 3'd6 raise illegalOp with outValid one cycle later, give wrEn low, and leave result and geFlags unchanged.
- R10: outValid is high exactly one cycle after inValid. wrEn is never high without outValid, and result and geFlags hold while no operation arrives.
- R11: A synchronous active-high reset clears geFlags, result, outValid, wrEn and illegalOp to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | An operation is presented this cycle |
| opSel | input | 3 | Operation selector code |
| condField | input | 4 | Condition field of the operation; 4'b1110 means always |
| condPass | input | 1 | External condition evaluation result |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| outValid | output | 1 | Result of last cycle's operation is presented |
| wrEn | output | 1 | Destination write enable for result |
| illegalOp | output | 1 | Last operation used an unused selector code |
| result | output | 32 | Packed lane result |
| geFlags | output | 4 | Greater-or-equal flags, one per byte position |

## Verification
A corrupted flag register shows on `geFlags` one cycle after the operation that caused it, and it stays wrong until the next executed operation overwrites it. A faulty hold path, where a skipped or illegal operation still loads its value, shows one cycle after that operation as a change in `result` or `geFlags` with `wrEn` low. The reference model tracks the held values across skipped operations, so such a change is caught at the very next comparison. A wrong lane mapping shows up at once as a mismatched byte or half of `result`.

// File: rtl/lane_addsub_pkg.sv
package lane_addsub_pkg;

  localparam logic [2:0] SEL_ADD16 = 3'd0;
  localparam logic [2:0] SEL_ASX   = 3'd1;
  localparam logic [2:0] SEL_SAX   = 3'd2;
  localparam logic [2:0] SEL_SUB16 = 3'd3;
  localparam logic [2:0] SEL_ADD8  = 3'd4;
  localparam logic [2:0] SEL_SUB8  = 3'd7;

  localparam logic [3:0] COND_ALWAYS = 4'b1110;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRes;     // commit new result and flags
    logic halfMode;    // 16-bit lane view
    logic crossHalves; // pair opA half h with opB half 1-h
    logic subLo;       // low half subtracts
    logic subHi;       // high half subtracts
    logic subByte;     // byte lanes subtract
  } dpStrobe_t;

endpackage

// File: rtl/lane_addsub_ctrl.sv
module lane_addsub_ctrl
  import lane_addsub_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [2:0] opSel,
  input  logic [3:0] condField,
  input  logic       condPass,
  output dpStrobe_t  strobe,
  output logic       outValid,
  output logic       wrEn,
  output logic       illegalOp
);

  logic legalSel;
  logic condOk;
  logic doExec;

  always_comb begin
    legalSel = 1'b1;
    strobe   = '0;
    unique case (opSel)
      SEL_ADD16: strobe.halfMode = 1'b1;
      SEL_ASX: begin
        strobe.halfMode    = 1'b1;
        strobe.crossHalves = 1'b1;
        strobe.subLo       = 1'b1;
      end
      SEL_SAX: begin
        strobe.halfMode    = 1'b1;
        strobe.crossHalves = 1'b1;
        strobe.subHi       = 1'b1;
      end
      SEL_SUB16: begin
        strobe.halfMode = 1'b1;
        strobe.subLo    = 1'b1;
        strobe.subHi    = 1'b1;
      end
      SEL_ADD8: strobe.subByte = 1'b0;
      SEL_SUB8: strobe.subByte = 1'b1;
      default:  legalSel = 1'b0;
    endcase
    condOk         = (condField == COND_ALWAYS) || condPass;
    doExec         = inValid && legalSel && condOk;
    strobe.loadRes = doExec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      wrEn      <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= inValid;
      wrEn      <= doExec;
      illegalOp <= inValid && !legalSel;
    end
  end

endmodule

// File: rtl/lane_addsub_dp.sv
module lane_addsub_dp
  import lane_addsub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpStrobe_t             strobe,
  input  logic [DATA_W-1:0]     opA,
  input  logic [DATA_W-1:0]     opB,
  output logic [DATA_W-1:0]     result,
  output logic [DATA_W/8-1:0]   geFlags
);

  localparam int HALF_W  = DATA_W / 2;
  localparam int BYTE_W  = 8;
  localparam int N_BYTE  = DATA_W / BYTE_W;
  localparam int GE_HALF = N_BYTE / 2;

  logic [1:0][HALF_W-1:0]        halfSum;
  logic [1:0]                    halfGe;
  logic [N_BYTE-1:0][BYTE_W-1:0] byteSum;
  logic [N_BYTE-1:0]             byteGe;
  logic [DATA_W-1:0]             nextRes;
  logic [N_BYTE-1:0]             nextGe;

  // two half lanes; subtraction as a + ~b + 1, carry out = GE
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] aPart;
    logic [HALF_W-1:0] bPart;
    logic              doSub;
    logic [HALF_W:0]   wide;
    always_comb begin
      aPart = opA[h*HALF_W +: HALF_W];
      bPart = strobe.crossHalves ? opB[(1-h)*HALF_W +: HALF_W]
                                 : opB[h*HALF_W +: HALF_W];
      doSub = (h == 0) ? strobe.subLo : strobe.subHi;
      wide  = {1'b0, aPart} + {1'b0, (doSub ? ~bPart : bPart)}
              + {{HALF_W{1'b0}}, doSub};
      halfSum[h] = wide[HALF_W-1:0];
      halfGe[h]  = wide[HALF_W];
    end
  end

  for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
    logic [BYTE_W-1:0] aPart;
    logic [BYTE_W-1:0] bPart;
    logic [BYTE_W:0]   wide;
    always_comb begin
      aPart = opA[i*BYTE_W +: BYTE_W];
      bPart = opB[i*BYTE_W +: BYTE_W];
      wide  = {1'b0, aPart} + {1'b0, (strobe.subByte ? ~bPart : bPart)}
              + {{BYTE_W{1'b0}}, strobe.subByte};
      byteSum[i] = wide[BYTE_W-1:0];
      byteGe[i]  = wide[BYTE_W];
    end
  end

  // in half mode each half outcome fans out to its GE_HALF flag bits
  for (genvar g = 0; g < N_BYTE; g++) begin : g_geSel
    assign nextGe[g] = strobe.halfMode ? halfGe[g / GE_HALF] : byteGe[g];
  end

  assign nextRes = strobe.halfMode ? halfSum : byteSum;

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      geFlags <= '0;
    end else if (strobe.loadRes) begin
      result  <= nextRes;
      geFlags <= nextGe;
    end
  end

endmodule

// File: rtl/lane_addsub_unit.sv
module lane_addsub_unit
  import lane_addsub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [2:0]          opSel,
  input  logic [3:0]          condField,
  input  logic                condPass,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  output logic                outValid,
  output logic                wrEn,
  output logic                illegalOp,
  output logic [DATA_W-1:0]   result,
  output logic [DATA_W/8-1:0] geFlags
);

  dpStrobe_t strobe;

  lane_addsub_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .opSel     (opSel),
    .condField (condField),
    .condPass  (condPass),
    .strobe    (strobe),
    .outValid  (outValid),
    .wrEn      (wrEn),
    .illegalOp (illegalOp)
  );

  lane_addsub_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .geFlags (geFlags)
  );

endmodule

// File: rtl/lane_addsub_chk.sv
module lane_addsub_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic [2:0]          opSel,
  input logic [3:0]          condField,
  input logic                condPass,
  input logic                outValid,
  input logic                wrEn,
  input logic                illegalOp,
  input logic [DATA_W-1:0]   result,
  input logic [DATA_W/8-1:0] geFlags
);

  logic condOk;
  assign condOk = (condField == 4'b1110) || condPass;

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (geFlags == '0) && (result == '0) && !outValid && !wrEn && !illegalOp);

  assert_half_pairs_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel <= 3'd3 && condOk) |=>
      (geFlags[0] == geFlags[1]) && (geFlags[2] == geFlags[3]));

  assert_cond_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (inValid && !condOk) |=> !wrEn && $stable(result) && $stable(geFlags));

  assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (inValid && (opSel == 3'd5 || opSel == 3'd6)) |=>
      illegalOp && outValid && !wrEn && $stable(geFlags) && $stable(result));

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid && !illegalOp && $stable(result) && $stable(geFlags));

  assert_wr_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> outValid);

endmodule

bind lane_addsub_unit lane_addsub_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/lane_addsub_unit_tb.sv
module lane_addsub_unit_tb;

  localparam time CYC = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [3:0]  condField = '0;
  logic        condPass = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid;
  logic        wrEn;
  logic        illegalOp;
  logic [31:0] result;
  logic [3:0]  geFlags;

  int checks = 0;
  int fails  = 0;

  logic [31:0] expRes = '0;
  logic [3:0]  expGe  = '0;

  always #(CYC/2) clk = ~clk;

  lane_addsub_unit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .condField(condField), .condPass(condPass), .opA(opA), .opB(opB),
    .outValid(outValid), .wrEn(wrEn), .illegalOp(illegalOp),
    .result(result), .geFlags(geFlags)
  );

  // behavioural reference for one operation
  task automatic refModel(input logic [2:0] sel, input logic [31:0] a, b,
                          output logic [31:0] r, output logic [3:0] g);
    int al, ah, bl, bh, lo, hi;
    bit gl, gh;
    al = int'(a[15:0]); ah = int'(a[31:16]);
    bl = int'(b[15:0]); bh = int'(b[31:16]);
    r = '0; g = '0;
    if (sel <= 3'd3) begin
      case (sel)
        3'd0: begin lo = al + bl; hi = ah + bh; gl = lo >= 65536; gh = hi >= 65536; end
        3'd1: begin lo = al - bh; hi = ah + bl; gl = lo >= 0;     gh = hi >= 65536; end
        3'd2: begin lo = al + bh; hi = ah - bl; gl = lo >= 65536; gh = hi >= 0;     end
        default: begin lo = al - bl; hi = ah - bh; gl = lo >= 0; gh = hi >= 0; end
      endcase
      r = {hi[15:0], lo[15:0]};
      g = {gh, gh, gl, gl};
    end else begin
      for (int i = 0; i < 4; i++) begin
        int x, y, s;
        x = int'(a[8*i +: 8]);
        y = int'(b[8*i +: 8]);
        if (sel == 3'd4) begin s = x + y; g[i] = s >= 256; end
        else             begin s = x - y; g[i] = s >= 0;   end
        r[8*i +: 8] = s[7:0];
      end
    end
  endtask

  function automatic string tagOf(input logic [2:0] sel);
    case (sel)
      3'd0: return "R1,R7";
      3'd1: return "R3,R7";
      3'd2: return "R4,R7";
      3'd3: return "R2,R7";
      3'd4: return "R5";
      3'd7: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic runOp(input logic [2:0] sel, input logic [3:0] cf, input logic cp,
                       input logic [31:0] a, b);
    logic legal, exec;
    logic [31:0] mr;
    logic [3:0] mg;
    string tag;
    opSel = sel; condField = cf; condPass = cp; opA = a; opB = b; inValid = 1'b1;
    legal = !(sel == 3'd5 || sel == 3'd6);
    exec  = legal && (cf == 4'b1110 || cp);
    refModel(sel, a, b, mr, mg);
    if (exec) begin expRes = mr; expGe = mg; end
    tag = !legal ? "R9" : (!exec ? "R8" : tagOf(sel));
    @(negedge clk);
    checks++;
    if (!(outValid === 1'b1 && wrEn === exec && illegalOp === !legal &&
          result === expRes && geFlags === expGe)) begin
      fails++;
      $display("FAIL %s sel=%0d a=%h b=%h: got v=%b w=%b ill=%b res=%h ge=%b exp w=%b ill=%b res=%h ge=%b",
               tag, sel, a, b, outValid, wrEn, illegalOp, result, geFlags,
               exec, !legal, expRes, expGe);
    end
    inValid = 1'b0;
  endtask

  task automatic idleCheck();
    inValid = 1'b0;
    opA = 32'hDEAD_BEEF; opB = 32'h1234_5678;
    @(negedge clk);
    checks++;
    if (!(outValid === 1'b0 && wrEn === 1'b0 && illegalOp === 1'b0 &&
          result === expRes && geFlags === expGe)) begin
      fails++;
      $display("FAIL R10 idle: got v=%b w=%b res=%h ge=%b exp v=0 w=0 res=%h ge=%b",
               outValid, wrEn, result, geFlags, expRes, expGe);
    end
  endtask

  logic finished = 1'b0;

  initial begin
    #(CYC * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (!(outValid === 1'b0 && wrEn === 1'b0 && illegalOp === 1'b0 &&
          result === 32'h0 && geFlags === 4'h0)) begin
      fails++;
      $display("FAIL R11 reset: got v=%b w=%b ill=%b res=%h ge=%b exp all zero",
               outValid, wrEn, illegalOp, result, geFlags);
    end
    rst = 1'b0;
    @(negedge clk);

    // corner cases
    runOp(3'd0, 4'hE, 1'b0, 32'hFFFF_FFFF, 32'h0001_0001); // R1 carry both halves
    runOp(3'd4, 4'hE, 1'b0, 32'hFFFF_FFFF, 32'h0101_0101); // R5 carry every byte
    runOp(3'd3, 4'hE, 1'b0, 32'h0000_0000, 32'h0001_0001); // R2 borrow both halves
    runOp(3'd7, 4'hE, 1'b0, 32'h0000_0000, 32'h0101_0101); // R6 borrow every byte
    runOp(3'd3, 4'hE, 1'b0, 32'h8765_4321, 32'h8765_4321); // R2 equal operands
    runOp(3'd7, 4'hE, 1'b0, 32'hA5A5_5A5A, 32'hA5A5_5A5A); // R6 equal operands
    runOp(3'd1, 4'hE, 1'b0, 32'hFFFF_0000, 32'h0001_0001); // R3 borrow lo, carry hi
    runOp(3'd2, 4'hE, 1'b0, 32'h0000_FFFF, 32'h0001_0001); // R4 carry lo, borrow hi
    runOp(3'd4, 4'hE, 1'b0, 32'h0080_FF01, 32'h0080_01FE); // R5 mixed carries
    idleCheck();                                           // R10 hold
    runOp(3'd0, 4'h0, 1'b0, 32'h1111_1111, 32'h2222_2222); // R8 skipped
    runOp(3'd0, 4'h0, 1'b1, 32'h1111_1111, 32'h2222_2222); // R8 condPass
    runOp(3'd5, 4'hE, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R9
    runOp(3'd6, 4'hE, 1'b0, 32'h0000_0000, 32'h0000_0001); // R9
    idleCheck();

    // random patterns over every selector
    for (int n = 0; n < 400; n++) begin
      logic [2:0] s;
      logic [3:0] cf;
      s  = 3'($urandom_range(0, 7));
      cf = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'hE;
      runOp(s, cf, 1'($urandom_range(0, 1)), $urandom, $urandom);
      if ($urandom_range(0, 7) == 0) idleCheck();
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule